// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Not-Most-Recently-Used Replacement

This block is a fully associative translation buffer for a 64-bit virtual address space with 8 KB pages. Each cycle it compares the virtual page number of the incoming address against every stored entry. It reports a hit or a miss in the same cycle. On a hit it forms the physical address from the stored frame number and the untranslated 13-bit page offset. Each entry carries an address-space tag. An entry can also be marked global, and then the tag comparison is skipped for it.

The hardware never walks a page table. After a miss, privileged software loads a new translation into staging inputs and pulses a write strobe. The buffer writes the translation into the lowest-indexed empty slot. When no slot is empty, a rotating pointer picks the victim and steps over the most recently used entry. Software can also drop every entry at once, or drop only the non-global entries of one address space. If two valid entries ever match one lookup, a flag is raised and the lowest-indexed entry is used.

Top module: `tlb_nmru`

## Requirements
- R1: On a hit, `lk_pa` equals the stored frame number concatenated with `lk_va[12:0]`. On a miss, `lk_pa` is zero.
- R2: A lookup hits only on a valid entry whose page number equals `lk_va[63:13]` and whose tag equals `lk_asid`, or which is marked global.
- R3: The lookup result is combinational on the current contents. A translation written at a clock edge is first visible in the cycle after it, and a lookup in the write cycle sees the old contents.
- R4: A write goes to the lowest-indexed invalid entry whenever one exists.
- R5: When all entries are valid, the victim is the rotating pointer's slot, or the next slot if the pointer equals the most-recently-used index. The pointer then moves to the slot after the victim, wrapping to 0.
- R6: The most-recently-used index takes the written slot on a write, or else the hitting slot on a hit. A write wins when both happen in one cycle.
- R7: `inv_all` makes every entry invalid from the next cycle.
- R8: `inv_asid_en` invalidates exactly the non-global entries whose tag equals `inv_asid`. Global entries and other tags stay.
- R9: If more than one valid entry matches, `lk_multi` is 1, `lk_hit` is 1 and the lowest-indexed matching entry supplies the frame. Otherwise `lk_multi` is 0.
- R10: A write in the same cycle as either invalidate command takes effect: the newly written entry is valid afterwards, and the invalidate applies to all other entries.
- R11: After synchronous active-low reset, all entries are invalid, so every lookup misses with `lk_multi` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 64 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one entry matched |
| lk_pa | output | 40 | Translated physical address (zero on miss) |
| wr_en | input | 1 | Write strobe for the staged translation |
| stg_vpn | input | 51 | Staged virtual page number |
| stg_asid | input | 8 | Staged address-space tag |
| stg_pfn | input | 27 | Staged physical frame number |
| stg_global | input | 1 | Staged global flag |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate non-global entries of one tag |
| inv_asid | input | 8 | Tag to invalidate |

## Verification
Two functions can fall in the same cycle: a software write, and an invalidate, either the flush of everything or the flush of one tag. The bench provokes this by raising the write strobe in the same clock as `inv_all`, and again in the same clock as `inv_asid_en` with the new entry carrying the tag being flushed. Lookups afterwards must show the new translation hitting and the older entries missing. The overlap of a write and a lookup is judged too: the lookup in the write cycle must miss, and the same lookup one cycle later must hit.

// File: rtl/tlb_nmru_pkg.sv
// Package: shared widths and the stored-entry record of the translation buffer.
// Assumes 8 KB pages and a 64-bit virtual address.
package tlb_nmru_pkg;
    localparam int VA_W      = 64;
    localparam int PAGE_BITS = 13;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int ASID_W    = 8;
    localparam int PFN_W     = 27;
    localparam int PA_W      = PFN_W + PAGE_BITS;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              glb;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
// Module: per-entry comparators. Raises match[i] when entry i is valid, its
// page number equals the lookup page, and its tag matches or it is global.
// Assumes the entry array and valid vector are registered state.
module tlb_match
    import tlb_nmru_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t        ent [N],
    input  logic [N-1:0]      valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // Compare one entry against the lookup key.
        always_comb begin
            match[i] = valid[i] && (ent[i].vpn == lk_vpn) &&
                       (ent[i].glb || (ent[i].asid == lk_asid));
        end
    end
endmodule

// File: rtl/tlb_prio.sv
// Module: picks the lowest-indexed set bit of a match vector and flags
// when more than one bit is set. Assumes N >= 2.
module tlb_prio #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic [IW-1:0] idx,
    output logic          any,
    output logic          multi
);
    // Scan from the top so that the lowest match is the one left in idx.
    always_comb begin
        idx   = '0;
        any   = 1'b0;
        multi = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                if (any) multi = 1'b1;
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the slot for the next software write. It uses the lowest
// invalid slot when there is one. Otherwise it uses the rotating pointer,
// stepped past the most-recently-used slot. Assumes N >= 2.
module tlb_victim #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [IW-1:0] ptr,
    input  logic [IW-1:0] mru,
    output logic [IW-1:0] victim,
    output logic [IW-1:0] ptr_next,
    output logic          full
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] free_idx;
    logic [IW-1:0] rot_idx;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
        return (v == LAST) ? '0 : v + 1'b1;
    endfunction

    // Find the lowest invalid slot.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IW'(i);
        end
    end

    // Rotating choice that never lands on the most-recently-used slot.
    always_comb begin
        full     = &valid;
        rot_idx  = (ptr == mru) ? step(ptr) : ptr;
        victim   = full ? rot_idx : free_idx;
        ptr_next = step(rot_idx);
    end
endmodule

// File: rtl/tlb_nmru.sv
// Module: fully associative, software-refilled translation buffer with
// address-space tags, global entries and not-most-recently-used replacement.
// Assumes software writes only after a miss. The lookup path is
// combinational from lk_va/lk_asid and the stored state.
module tlb_nmru
    import tlb_nmru_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  stg_vpn,
    input  logic [ASID_W-1:0] stg_asid,
    input  logic [PFN_W-1:0]  stg_pfn,
    input  logic              stg_global,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid
);
    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] valid_d;
    logic [IW-1:0]      mru_q;
    logic [IW-1:0]      ptr_q;
    logic [ENTRIES-1:0] match;
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      victim;
    logic [IW-1:0]      ptr_next;
    logic               full;

    tlb_match #(.N(ENTRIES)) u_match (
        .ent     (ent_q),
        .valid   (valid_q),
        .lk_vpn  (lk_va[VA_W-1:PAGE_BITS]),
        .lk_asid (lk_asid),
        .match   (match)
    );

    tlb_prio #(.N(ENTRIES), .IW(IW)) u_prio (
        .match (match),
        .idx   (hit_idx),
        .any   (lk_hit),
        .multi (lk_multi)
    );

    tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .valid    (valid_q),
        .ptr      (ptr_q),
        .mru      (mru_q),
        .victim   (victim),
        .ptr_next (ptr_next),
        .full     (full)
    );

    // Form the physical address: frame from the hit entry, offset passed through.
    always_comb begin
        lk_pa = lk_hit ? {ent_q[hit_idx].pfn, lk_va[PAGE_BITS-1:0]} : '0;
    end

    // Next valid bits: invalidates first, then the written slot is set.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_d[i] = valid_q[i];
            if (inv_all) begin
                valid_d[i] = 1'b0;
            end else if (inv_asid_en && !ent_q[i].glb &&
                         ent_q[i].asid == inv_asid) begin
                valid_d[i] = 1'b0;
            end
            if (wr_en && victim == IW'(i)) valid_d[i] = 1'b1;
        end
    end

    // Entry storage: load the staged translation into the chosen slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[victim] <= '{vpn: stg_vpn, asid: stg_asid,
                               pfn: stg_pfn, glb: stg_global};
        end
    end

    // Valid vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Most-recently-used index: the write takes precedence over the hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      mru_q <= '0;
        else if (wr_en)  mru_q <= victim;
        else if (lk_hit) mru_q <= hit_idx;
    end

    // Rotating pointer moves only on a write that had to evict.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (wr_en && full)  ptr_q <= ptr_next;
    end
endmodule

// File: rtl/tlb_nmru_chk.sv
// Module: assertion checker for tlb_nmru, attached by the bind below.
// Assumes it observes the internal valid vector, MRU index and victim.
module tlb_nmru_chk
    import tlb_nmru_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VA_W-1:0]    lk_va,
    input logic               lk_hit,
    input logic               lk_multi,
    input logic [PA_W-1:0]    lk_pa,
    input logic               wr_en,
    input logic               inv_all,
    input logic [ENTRIES-1:0] valid_q,
    input logic [IW-1:0]      mru_q,
    input logic [IW-1:0]      victim
);
    AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pa == '0); // R1
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]); // R1
    AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit); // R9
    AST_INVALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all && !wr_en |=> valid_q == '0); // R7
    AST_WRITE_SETS_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mru_q == $past(victim)) && valid_q[mru_q]); // R6
    AST_VICTIM_NOT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (&valid_q) |-> victim != mru_q); // R5
    AST_WRITE_SURVIVES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && inv_all |=> $countones(valid_q) == 1); // R10
endmodule

bind tlb_nmru tlb_nmru_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_va    (lk_va),
    .lk_hit   (lk_hit),
    .lk_multi (lk_multi),
    .lk_pa    (lk_pa),
    .wr_en    (wr_en),
    .inv_all  (inv_all),
    .valid_q  (valid_q),
    .mru_q    (mru_q),
    .victim   (victim)
);

// File: tb/tlb_nmru_tb_top.sv
// Bench: a table of operations with expected lookup results, then directed
// tests for reset, replacement order, duplicate matches and same-cycle overlaps.
module tlb_nmru_tb_top;
    import tlb_nmru_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic              lk_multi;
    logic [PA_W-1:0]   lk_pa;
    logic              wr_en = 1'b0;
    logic [VPN_W-1:0]  stg_vpn = '0;
    logic [ASID_W-1:0] stg_asid = '0;
    logic [PFN_W-1:0]  stg_pfn = '0;
    logic              stg_global = 1'b0;
    logic              inv_all = 1'b0;
    logic              inv_asid_en = 1'b0;
    logic [ASID_W-1:0] inv_asid = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    tlb_nmru dut_i (.*);

    typedef enum logic [1:0] {OP_LOOK, OP_WRITE, OP_FLUSH, OP_FLUSH_TAG} op_e;
    typedef struct packed {
        op_e               op;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              glb;
        logic              hit;
    } vec_t;

    localparam logic [VPN_W-1:0] VA = 51'h4_0000_0000_0100;
    localparam logic [VPN_W-1:0] VB = 51'h0_0000_0ABC_D200;

    localparam vec_t VEC [16] = '{
        '{OP_WRITE,     VA, 8'd1, 27'h0AAA, 1'b0, 1'b0},
        '{OP_WRITE,     VB, 8'd2, 27'h0BBB, 1'b1, 1'b0},
        '{OP_WRITE,     VA, 8'd3, 27'h0CCC, 1'b0, 1'b0},
        '{OP_LOOK,      VA, 8'd1, 27'h0AAA, 1'b0, 1'b1},  // R2 own tag
        '{OP_LOOK,      VA, 8'd3, 27'h0CCC, 1'b0, 1'b1},  // R2 other tag
        '{OP_LOOK,      VA, 8'd2, 27'h0,    1'b0, 1'b0},  // R2 tag mismatch
        '{OP_LOOK,      VB, 8'd7, 27'h0BBB, 1'b0, 1'b1},  // R2 global
        '{OP_LOOK,      VA + 1'b1, 8'd1, 27'h0, 1'b0, 1'b0},  // R2 page mismatch
        '{OP_FLUSH_TAG, '0, 8'd1, 27'h0,    1'b0, 1'b0},
        '{OP_LOOK,      VA, 8'd1, 27'h0,    1'b0, 1'b0},  // R8 removed
        '{OP_LOOK,      VA, 8'd3, 27'h0CCC, 1'b0, 1'b1},  // R8 kept
        '{OP_FLUSH_TAG, '0, 8'd2, 27'h0,    1'b0, 1'b0},
        '{OP_LOOK,      VB, 8'd2, 27'h0BBB, 1'b0, 1'b1},  // R8 global kept
        '{OP_FLUSH,     '0, 8'd0, 27'h0,    1'b0, 1'b0},
        '{OP_LOOK,      VB, 8'd2, 27'h0,    1'b0, 1'b0},  // R7
        '{OP_LOOK,      VA, 8'd3, 27'h0,    1'b0, 1'b0}   // R7
    };

    // Compare the lookup outputs against expected values.
    task automatic check_now(input string req, input logic e_hit,
                             input logic [PA_W-1:0] e_pa, input logic e_multi);
        n_chk++;
        if (lk_hit !== e_hit || lk_pa !== e_pa || lk_multi !== e_multi) begin
            n_bad++;
            $display("FAIL %s: hit=%0b pa=%h multi=%0b, expected hit=%0b pa=%h multi=%0b",
                     req, lk_hit, lk_pa, lk_multi, e_hit, e_pa, e_multi);
        end
    endtask

    // Apply one lookup at a falling edge and check it before the next rise.
    task automatic look(input string req, input logic [VPN_W-1:0] vpn,
                        input logic [ASID_W-1:0] asid, input logic [PAGE_BITS-1:0] off,
                        input logic e_hit, input logic [PFN_W-1:0] e_pfn,
                        input logic e_multi);
        @(negedge clk);
        lk_va   = {vpn, off};
        lk_asid = asid;
        #1;
        check_now(req, e_hit, e_hit ? {e_pfn, off} : '0, e_multi);
    endtask

    // Park the lookup on an address that never hits.
    task automatic park();
        lk_va   = '1;
        lk_asid = 8'hFF;
    endtask

    // Stage and strobe one write for a single cycle.
    task automatic put(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                       input logic [PFN_W-1:0] pfn, input logic glb);
        @(negedge clk);
        park();
        stg_vpn = vpn; stg_asid = asid; stg_pfn = pfn; stg_global = glb;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic flush_all();
        @(negedge clk);
        park();
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic flush_tag(input logic [ASID_W-1:0] a);
        @(negedge clk);
        park();
        inv_asid_en = 1'b1; inv_asid = a;
        @(negedge clk);
        inv_asid_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        park();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R11: empty after reset.
        look("R11", VA, 8'd1, 13'h1A5, 1'b0, '0, 1'b0);
        look("R11", '0, 8'd0, 13'h0, 1'b0, '0, 1'b0);

        // Table walk.
        for (int i = 0; i < 16; i++) begin
            case (VEC[i].op)
                OP_WRITE:     put(VEC[i].vpn, VEC[i].asid, VEC[i].pfn, VEC[i].glb);
                OP_FLUSH:     flush_all();
                OP_FLUSH_TAG: flush_tag(VEC[i].asid);
                default:      look($sformatf("R2/R7/R8 vec%0d", i), VEC[i].vpn,
                                   VEC[i].asid, 13'(i * 311 + 5), VEC[i].hit,
                                   VEC[i].pfn, 1'b0);
            endcase
        end

        // R1: offset passes through at its extremes.
        put(VB, 8'd4, 27'h7FF_FFFF, 1'b0);
        look("R1", VB, 8'd4, 13'h1FFF, 1'b1, 27'h7FF_FFFF, 1'b0);
        look("R1", VB, 8'd4, 13'h0000, 1'b1, 27'h7FF_FFFF, 1'b0);

        // R4: the lowest free slot is reused. D duplicates C, so D only wins
        // (lowest index) if it landed in freed slot 1.
        do_reset();
        put(51'h10, 8'd1, 27'h11, 1'b0);   // slot 0
        put(51'h20, 8'd2, 27'h22, 1'b0);   // slot 1
        put(51'h30, 8'd3, 27'h33, 1'b0);   // slot 2
        flush_tag(8'd2);
        put(51'h30, 8'd3, 27'h44, 1'b0);   // expected slot 1
        look("R4", 51'h30, 8'd3, 13'h7, 1'b1, 27'h44, 1'b1);
        // R9: duplicate raises the flag, lowest index wins.
        look("R9", 51'h30, 8'd3, 13'h8, 1'b1, 27'h44, 1'b1);
        look("R9", 51'h10, 8'd1, 13'h9, 1'b1, 27'h11, 1'b0);

        // R5/R6: fill all 16 slots, touch slot 0, then evict.
        do_reset();
        for (int i = 0; i < 16; i++) put(51'h1000 + 51'(i), 8'd5, 27'h100 + 27'(i), 1'b0);
        look("R6", 51'h1000, 8'd5, 13'h3, 1'b1, 27'h100, 1'b0);  // MRU becomes 0
        put(51'h2000, 8'd5, 27'h777, 1'b0);   // pointer 0 is MRU -> slot 1
        look("R5", 51'h1001, 8'd5, 13'h3, 1'b0, '0, 1'b0);
        look("R5", 51'h1000, 8'd5, 13'h3, 1'b1, 27'h100, 1'b0);
        look("R5", 51'h2000, 8'd5, 13'h3, 1'b1, 27'h777, 1'b0);  // MRU now 1
        put(51'h3000, 8'd5, 27'h888, 1'b0);   // pointer 2, not MRU -> slot 2
        look("R5", 51'h1002, 8'd5, 13'h4, 1'b0, '0, 1'b0);
        look("R5", 51'h1003, 8'd5, 13'h4, 1'b1, 27'h103, 1'b0);
        look("R5", 51'h3000, 8'd5, 13'h4, 1'b1, 27'h888, 1'b0);

        // R3: lookup in the write cycle sees old contents, next cycle sees new.
        do_reset();
        @(negedge clk);
        lk_va = {51'h5555, 13'h12}; lk_asid = 8'd6;
        stg_vpn = 51'h5555; stg_asid = 8'd6; stg_pfn = 27'h9999; stg_global = 1'b0;
        wr_en = 1'b1;
        #1;
        check_now("R3", 1'b0, '0, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check_now("R3", 1'b1, {27'h9999, 13'h12}, 1'b0);

        // R10: write together with flush-all; only the new entry remains.
        @(negedge clk);
        park();
        stg_vpn = 51'h6666; stg_asid = 8'd6; stg_pfn = 27'h6161; stg_global = 1'b0;
        wr_en = 1'b1; inv_all = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; inv_all = 1'b0;
        look("R10", 51'h6666, 8'd6, 13'h1, 1'b1, 27'h6161, 1'b0);
        look("R10", 51'h5555, 8'd6, 13'h1, 1'b0, '0, 1'b0);

        // R10: write with flush-by-tag of the same tag; new entry survives.
        @(negedge clk);
        park();
        stg_vpn = 51'h7777; stg_asid = 8'd6; stg_pfn = 27'h7171; stg_global = 1'b0;
        wr_en = 1'b1; inv_asid_en = 1'b1; inv_asid = 8'd6;
        @(negedge clk);
        wr_en = 1'b0; inv_asid_en = 1'b0;
        look("R10", 51'h7777, 8'd6, 13'h2, 1'b1, 27'h7171, 1'b0);
        look("R10", 51'h6666, 8'd6, 13'h2, 1'b0, '0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule